// File: doc/BRIEF.md
# Serial-loaded bank register port

This block is the write side of a cartridge memory mapper. The host CPU cannot write a bank register in one bus cycle. Instead it feeds the block one data bit per bus write into the upper half of the address space. After five accepted writes, the gathered 5-bit value is stored in one of four registers: a mode/control register, two character bank registers and a program bank register.

The address of the fifth write picks the destination. A write whose data has its top bit set is a reset write. It drops any partial value and forces two mode bits in the control register. The register outputs feed address translation logic elsewhere. That logic, the read paths and the memory arrays are not part of this block.

Top module: `bankreg_serial_port`

## Requirements
- R1: After a synchronous active-low reset, the control output is 0x0C and both character bank outputs, the program bank output and the internal partial value are all zero.
- R2: A strobed write with address bit 15 low changes nothing. The registers stay as they are, and so do the partial value and the count of bits gathered so far.
- R3: A strobed write to address bit 15 high with data bit 7 set drops the partial value and the bit count. The next five accepted writes then build a complete fresh value.
- R4: That reset write ORs 0x0C into the control register and leaves both character bank registers and the program bank register unchanged.
- R5: Each accepted write with data bit 7 clear contributes data bit 0. The first write supplies bit 0 of the value and the fifth supplies bit 4. Data bits 6:1 have no effect.
- R6: Only the fifth write's address bits 14:13 choose the destination: 0 is control, 1 is character bank 0, 2 is character bank 1 and 3 is the program bank. The addresses of writes one to four do not matter.
- R7: The program bank register keeps only bits 3:0 of the value. The other three registers keep all 5 bits.
- R8: Once a value is stored, the partial value and bit count return to zero, so the next write starts a new value.
- R9: The register outputs change only on the clock edge of a completing fifth write or of a reset write.
- R10: The strobe held high on consecutive cycles counts as one write per cycle.
- R11: Cycles with the strobe low have no effect, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one write per high cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ctrl_reg | output | 5 | Control register |
| chr_lo_bank | output | 5 | Character bank register 0 |
| chr_hi_bank | output | 5 | Character bank register 1 |
| prg_bank | output | 4 | Program bank register |

## Verification
The bit count and partial value cannot be seen directly. A wrong count or a leftover bit shows up only when the next value is stored. That is up to five writes later, as a value with misplaced bits or a store landing one write early or late in the wrong register. The bench keeps a bit-level model of that hidden progress. It compares all four outputs after every write, so a drifting count is caught on the first store that follows it. Reset writes and writes with bit 15 low are placed in the middle of sequences, which exposes progress that is not cleared or not held.

// File: rtl/bankreg_pkg.sv
// Package: shared sizes, reset constants and destination encoding for the
// serial bank register port. Assumes a 16-bit CPU address and 8-bit data.
package bankreg_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int SHIFT_W  = 5;
    localparam int PRG_KEEP = 4;
    localparam int CNT_W    = $clog2(SHIFT_W);

    // Control register value after reset, and bits forced by a reset write
    localparam logic [SHIFT_W-1:0] CTRL_RESET = 5'h0C;
    localparam logic [SHIFT_W-1:0] CTRL_FORCE = 5'h0C;

    // Destination selected by address bits 14:13 on the completing write
    typedef enum logic [1:0] {
        DST_CTRL   = 2'd0,
        DST_CHR_LO = 2'd1,
        DST_CHR_HI = 2'd2,
        DST_PRG    = 2'd3
    } dest_e;
endpackage

// File: rtl/bankreg_shifter.sv
// Module: bankreg_shifter
// Gathers one bit per accepted write, LSB first. It raises a one-cycle store
// request with the complete value on the write that supplies the last bit.
// A reset write drops the partial value. Assumes the caller has already
// qualified writes by the address window.
module bankreg_shifter
    import bankreg_pkg::*;
#(
    parameter int WIDTH = SHIFT_W,
    localparam int CW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,     // strobed write inside the window
    input  logic             abort_bit,  // data bit 7
    input  logic             data_bit,   // data bit 0
    output logic             abort,      // reset write this cycle
    output logic             store,      // completing write this cycle
    output logic [WIDTH-1:0] value       // full value, valid with store
);
    logic [WIDTH-1:0] acc_q;
    logic [CW-1:0]    cnt_q;
    logic             load;

    // Classify the current write
    always_comb begin
        abort = accept && abort_bit;
        load  = accept && !abort_bit;
        store = load && (cnt_q == CW'(WIDTH - 1));
        value = acc_q | (WIDTH'(data_bit) << cnt_q);
    end

    // Partial value and bit count
    always_ff @(posedge clk) begin
        if (!rst_n || abort || store) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            acc_q <= value;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The count never reaches the width
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(WIDTH));
    // A reset write leaves no progress behind
    assert_abort_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (cnt_q == '0 && acc_q == '0));
    // A store leaves no progress behind
    assert_store_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (cnt_q == '0 && acc_q == '0));
    // Nothing accepted means progress holds
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(cnt_q) && $stable(acc_q)));
endmodule

// File: rtl/bankreg_file.sv
// Module: bankreg_file
// Holds the four bank registers. It stores a full value into the selected
// register on a store request and forces mode bits on a reset write.
// Assumes store and abort are never high together.
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int WIDTH = SHIFT_W,
    parameter int PRG_W = PRG_KEEP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store,
    input  logic             abort,
    input  dest_e            dest,
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] ctrl_q,
    output logic [WIDTH-1:0] chr_q [2],
    output logic [PRG_W-1:0] prg_q
);
    // Control register: store, or OR in the forced mode bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (abort)
            ctrl_q <= ctrl_q | CTRL_FORCE;
        else if (store && dest == DST_CTRL)
            ctrl_q <= value;
    end

    // Character bank registers, one per bank slot
    for (genvar g = 0; g < 2; g++) begin : g_chr
        localparam dest_e MY_DEST = (g == 0) ? DST_CHR_LO : DST_CHR_HI;
        always_ff @(posedge clk) begin
            if (!rst_n)
                chr_q[g] <= '0;
            else if (store && dest == MY_DEST)
                chr_q[g] <= value;
        end
        assert_chr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(store && dest == MY_DEST) |=> $stable(chr_q[g]));
    end

    // Program bank register: keeps the low bits only
    always_ff @(posedge clk) begin
        if (!rst_n)
            prg_q <= '0;
        else if (store && dest == DST_PRG)
            prg_q <= value[PRG_W-1:0];
    end

    // A reset write sets the forced bits
    assert_abort_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> ((ctrl_q & CTRL_FORCE) == CTRL_FORCE));
    // Control moves only on a reset write or a store to it
    assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort || (store && dest == DST_CTRL)) |=> $stable(ctrl_q));
    // Program bank moves only on a store to it
    assert_prg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(store && dest == DST_PRG) |=> $stable(prg_q));
    // Store and reset write are exclusive
    assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(store && abort));
endmodule

// File: rtl/bankreg_serial_port.sv
// Module: bankreg_serial_port
// Top of the serial-loaded bank register port. It qualifies CPU writes by
// address bit 15, feeds them to the bit gatherer and routes completed values
// into the register file. Assumes one write per high strobe cycle.
module bankreg_serial_port
    import bankreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [SHIFT_W-1:0]  ctrl_reg,
    output logic [SHIFT_W-1:0]  chr_lo_bank,
    output logic [SHIFT_W-1:0]  chr_hi_bank,
    output logic [PRG_KEEP-1:0] prg_bank
);
    logic               accept;
    logic               abort;
    logic               store;
    logic [SHIFT_W-1:0] value;
    dest_e              dest;
    logic [SHIFT_W-1:0] chr_q [2];
    logic               unused_bits;

    // Window qualification and destination decode
    always_comb begin
        accept      = wr_en && wr_addr[ADDR_W-1];
        dest        = dest_e'(wr_addr[ADDR_W-2 -: 2]);
        unused_bits = ^{wr_data[DATA_W-2:1], wr_addr[ADDR_W-4:0]};
    end

    bankreg_shifter #(.WIDTH(SHIFT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .abort_bit (wr_data[DATA_W-1]),
        .data_bit  (wr_data[0]),
        .abort     (abort),
        .store     (store),
        .value     (value)
    );

    bankreg_file #(.WIDTH(SHIFT_W), .PRG_W(PRG_KEEP)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .store  (store),
        .abort  (abort),
        .dest   (dest),
        .value  (value),
        .ctrl_q (ctrl_reg),
        .chr_q  (chr_q),
        .prg_q  (prg_bank)
    );

    // Output naming
    always_comb begin
        chr_lo_bank = chr_q[0];
        chr_hi_bank = chr_q[1];
    end

    // Writes outside the window never reach the register file
    assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[ADDR_W-1]) |-> !(store || abort));
    // Strobe low never reaches the register file
    assert_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !(store || abort));
endmodule

// File: tb/sim_bankreg_serial_port.sv
module sim_bankreg_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [4:0]  ctrl_reg, chr_lo_bank, chr_hi_bank;
    logic [3:0]  prg_bank;

    int n_checks = 0;
    int n_fail = 0;

    // Bench model of the block
    logic [4:0] m_ctrl, m_chr0, m_chr1, m_acc;
    logic [3:0] m_prg;
    int         m_cnt;

    always #2 clk = ~clk;  // 250 MHz

    bankreg_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_reg(ctrl_reg), .chr_lo_bank(chr_lo_bank),
        .chr_hi_bank(chr_hi_bank), .prg_bank(prg_bank)
    );

    function automatic logic [18:0] expected_regs();
        return {m_ctrl, m_chr0, m_chr1, m_prg};
    endfunction

    task automatic model_reset();
        m_ctrl = 5'h0C; m_chr0 = '0; m_chr1 = '0; m_prg = '0;
        m_acc = '0; m_cnt = 0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (!a[15]) return;
        if (d[7]) begin
            m_acc = '0; m_cnt = 0; m_ctrl = m_ctrl | 5'h0C;
            return;
        end
        m_acc[m_cnt] = d[0];
        m_cnt++;
        if (m_cnt == 5) begin
            case (a[14:13])
                2'd0: m_ctrl = m_acc;
                2'd1: m_chr0 = m_acc;
                2'd2: m_chr1 = m_acc;
                default: m_prg = m_acc[3:0];
            endcase
            m_acc = '0; m_cnt = 0;
        end
    endtask

    task automatic check(input string tag, input logic [18:0] exp);
        logic [18:0] act;
        act = {ctrl_reg, chr_lo_bank, chr_hi_bank, prg_bank};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One strobed write; consecutive calls keep the strobe high
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        model_write(a, d);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Five writes, LSB first; the fifth carries the destination address
    task automatic load5(input logic [15:0] a, input logic [4:0] v);
        for (int i = 0; i < 5; i++) wr(a, {7'b0110100, v[i]});
    endtask

    initial begin : watchdog
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", {5'h0C, 5'h00, 5'h00, 4'h0});
        @(negedge clk); rst_n = 1'b1;

        // R5, R9: LSB-first value into character bank 0, stable until 5th
        for (int i = 0; i < 4; i++) begin
            wr(16'hA000, {7'b0, 5'b01101 >> i} & 8'h01 | 8'h00);
            check("R9 no change before fifth write", {5'h0C, 5'h00, 5'h00, 4'h0});
        end
        wr(16'hA000, 8'h00);
        check("R5 LSB-first value 0x0D", {5'h0C, 5'h0D, 5'h00, 4'h0});

        // R2: window misses in the middle of a sequence
        idle(1);
        wr(16'hC000, 8'h01);
        wr(16'h7FFF, 8'h81);
        check("R2 low-address reset write ignored", {5'h0C, 5'h0D, 5'h00, 4'h0});
        wr(16'h0000, 8'h01);
        for (int i = 0; i < 4; i++) wr(16'hC000, 8'h00);
        check("R2 low-address writes added no bits", {5'h0C, 5'h0D, 5'h01, 4'h0});

        // R6: earlier addresses point elsewhere; the fifth picks control
        for (int i = 0; i < 4; i++) wr(16'hE000, 8'h00);
        wr(16'h8000, 8'h00);
        check("R6 fifth address picks control", {5'h00, 5'h0D, 5'h01, 4'h0});

        // R4 and R3: reset write mid-sequence
        wr(16'hE000, 8'h01);
        wr(16'hE000, 8'h01);
        wr(16'hFFFF, 8'h80);
        check("R4 reset write forces 0x0C only", {5'h0C, 5'h0D, 5'h01, 4'h0});
        load5(16'hE000, 5'b10010);
        check("R3 fresh five bits after reset write", {5'h0C, 5'h0D, 5'h01, 4'h2});

        // R7: program bank keeps low four bits
        load5(16'hFFFF, 5'b11111);
        check("R7 program bank truncation", {5'h0C, 5'h0D, 5'h01, 4'hF});

        // R8: back-to-back stores with no stray bit carried over
        load5(16'hA000, 5'b10000);
        load5(16'hA000, 5'b00001);
        check("R8 progress cleared after store", {5'h0C, 5'h01, 5'h01, 4'hF});

        // R11: strobe low with tempting bus values
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 16'h8000; wr_data = 8'h80;
        repeat (3) @(posedge clk);
        #1;
        check("R11 strobe low has no effect", {5'h0C, 5'h01, 5'h01, 4'hF});
        load5(16'h8000, 5'b00011);
        check("R11 no hidden progress from idle", {5'h03, 5'h01, 5'h01, 4'hF});

        // R10: strobe held high across five cycles makes one store
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'hC000; wr_data = 8'h01;
        repeat (5) @(posedge clk);
        #1;
        for (int i = 0; i < 5; i++) model_write(16'hC000, 8'h01);
        check("R10 held strobe counts each cycle", {5'h03, 5'h01, 5'h1F, 4'hF});
        check("R10 model agrees", expected_regs());
        idle(1);

        // Random traffic against the model (R5, R6, R2, R3, R4)
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom());
            d = 8'($urandom());
            if (($urandom() % 12) != 0) d[7] = 1'b0;
            if (($urandom() % 8) == 0) a[15] = 1'b0; else a[15] = 1'b1;
            wr(a, d);
            check("R5 random write vs model", expected_regs());
            if (($urandom() % 16) == 0) begin
                idle(1 + int'($urandom() % 3));
                check("R11 random idle vs model", expected_regs());
            end
        end

        // R1: reset in the middle of a sequence
        wr(16'hA000, 8'h01);
        @(negedge clk); wr_en = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        model_reset();
        check("R1 reset mid-sequence", {5'h0C, 5'h00, 5'h00, 4'h0});
        @(negedge clk); rst_n = 1'b1;
        load5(16'hA000, 5'b00100);
        check("R1 progress cleared by reset", {5'h0C, 5'h04, 5'h00, 4'h0});

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule